// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned 4-bit operands and returns a 9-bit product. It handles one multiplier bit per step instead of building a full array. A single accumulator register does two jobs. At the start it holds the multiplier in its low end. As the multiplier bits shift out to the right, the partial product grows into the upper end.

A controller watches the accumulator's least-significant bit and sends strobes to the datapath. A load strobe captures the operands. An add strobe adds the multiplicand into the upper half and writes the carry into the top bit. A shift strobe moves the whole register one place to the right. An add always takes its own cycle and is always followed by a shift cycle. A multiplier bit of zero therefore costs one cycle, and a bit of one costs two.

When the last bit has been handled, the block raises done for a single cycle. The product then holds until the next start is accepted. Start requests that arrive while a multiplication is under way are dropped.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is asserted and after it is released, with no start seen, the product reads 0 and done is low.
- R2: A start accepted while idle loads the register. In the cycle after the accepting edge, the product bits 3..0 equal the multiplier and bits 8..4 read 0, whatever an earlier run left there.
- R3: The multiplicand and multiplier are captured on the accepting edge. Changes to the operand inputs after that edge have no effect on the result.
- R4: When done is high, the product equals the multiplicand times the multiplier as an unsigned 9-bit number. For example, 15 times 15 gives 225, which is 011100001 in binary.
- R5: Done is high in the cycle that follows the (4 + N)-th clock edge after the accepting edge, where N is the number of one bits in the multiplier.
- R6: Done is high for exactly one cycle per multiplication, and the block is idle in the following cycle.
- R7: A start that arrives during a multiplication, including the done cycle, is ignored. It does not restart the block or change the result.
- R8: From the done cycle until the next accepted start, the product holds its value.
- R9: Every add cycle is followed directly by a shift cycle. Each multiplication performs exactly four shifts.
- R10: An add uses product bits 7..4 with the multiplicand and writes its 5-bit result, carry included, into bits 8..4. Bit 8 is always 0 when an add takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication; acted on only when idle |
| mcand | input | 4 | Multiplicand, unsigned |
| mplier | input | 4 | Multiplier, unsigned |
| product | output | 9 | Accumulator contents; holds the product once done has pulsed |
| done | output | 1 | One-cycle pulse when the product is ready |

## Verification
The clash that matters is a start request landing in the same cycle as work already in progress: an add or shift step, or the done cycle itself. The bench provokes this in two ways. It pulses start with different operands partway through a run. It also holds start high from the load until done appears, then drops it in the done cycle. A behavioural model steps alongside the design every clock. It expects the request to be dropped, the original product to appear, done to pulse exactly once, and the product to stay put in the idle cycles that follow.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

  // Strobes sent from the controller to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;
    logic add;
    logic shift;
  } ctlStrobe_t;

endpackage

// File: rtl/sam_datapath.sv
module sam_datapath
  import shift_add_mul_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [OP_W-1:0]     mcandIn,
  input  logic [OP_W-1:0]     mplierIn,
  output logic [2*OP_W:0]     accOut,
  output logic                accLsb
);

  localparam int ACC_W = 2 * OP_W + 1;
  localparam int HI_LO = OP_W;          // lowest bit of the adder window
  localparam int HI_HI = 2 * OP_W - 1;  // highest bit the adder reads

  logic [ACC_W-1:0] accQ;
  logic [OP_W-1:0]  mcandQ;
  logic [OP_W:0]    carry;
  logic [OP_W-1:0]  sumBits;
  logic [OP_W:0]    addRes;

  // Ripple chain of full adders over the window accQ[HI_HI:HI_LO]; the top accumulator bit is not an input
  assign carry[0] = 1'b0;
  for (genvar i = 0; i < OP_W; i++) begin : gFullAdd
    logic opA;
    logic opB;
    assign opA          = accQ[HI_LO + i];
    assign opB          = mcandQ[i];
    assign sumBits[i]   = opA ^ opB ^ carry[i];
    assign carry[i + 1] = (opA & opB) | (opA & carry[i]) | (opB & carry[i]);
  end
  assign addRes = {carry[OP_W], sumBits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      mcandQ <= '0;
    end else if (strobe.load) begin
      accQ   <= {{(OP_W + 1){1'b0}}, mplierIn};
      mcandQ <= mcandIn;
    end else if (strobe.add) begin
      accQ[ACC_W-1:HI_LO] <= addRes;
    end else if (strobe.shift) begin
      accQ <= {1'b0, accQ[ACC_W-1:1]};
    end
  end

  assign accOut = accQ;
  assign accLsb = accQ[0];

  // R2: load clears the upper part and places the multiplier at the bottom
  a_r2_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> accQ == {{(OP_W + 1){1'b0}}, $past(mplierIn)});

  // R10: the top bit is empty whenever an add is issued
  a_r10_top_empty_on_add: assert property (@(posedge clk) disable iff (!rstN)
    strobe.add |-> !accQ[ACC_W-1]);

  // R10: an add writes window plus multiplicand into the upper bits and leaves the low bits alone
  a_r10_add_result: assert property (@(posedge clk) disable iff (!rstN)
    strobe.add |=> (accQ[ACC_W-1:HI_LO] ==
                    ({1'b0, $past(accQ[HI_HI:HI_LO])} + {1'b0, $past(mcandQ)}))
                   && (accQ[HI_LO-1:0] == $past(accQ[HI_LO-1:0])));

  // R8: without a strobe the register holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.add || strobe.shift) |=> $stable(accQ));

endmodule

// File: rtl/sam_control.sv
module sam_control
  import shift_add_mul_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       accLsb,
  output ctlStrobe_t strobe,
  output logic       done
);

  // State 0 idle, odd states 1..2*OP_W-1 test a bit, even states 2..2*OP_W shift after an add,
  // state 2*OP_W+1 signals completion.
  localparam int NUM_ST = 2 * OP_W + 2;
  localparam int SW     = $clog2(NUM_ST);
  localparam logic [SW-1:0] ST_IDLE = '0;
  localparam logic [SW-1:0] ST_LAST = SW'(NUM_ST - 1);

  logic [SW-1:0] stateQ;
  logic [SW-1:0] stateD;

  always_comb begin
    strobe = '0;
    done   = 1'b0;
    stateD = stateQ;
    if (stateQ == ST_IDLE) begin
      if (start) begin
        strobe.load = 1'b1;
        stateD      = SW'(1);
      end
    end else if (stateQ == ST_LAST) begin
      done   = 1'b1;
      stateD = ST_IDLE;
    end else if (stateQ > ST_LAST) begin
      stateD = ST_IDLE;
    end else if (stateQ[0]) begin
      if (accLsb) begin
        strobe.add = 1'b1;
        stateD     = stateQ + SW'(1);
      end else begin
        strobe.shift = 1'b1;
        stateD       = stateQ + SW'(2);
      end
    end else begin
      strobe.shift = 1'b1;
      stateD       = stateQ + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // Shift tally used only by the checks below
  logic [SW-1:0] shiftTally;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftTally <= '0;
    else if (strobe.load)  shiftTally <= '0;
    else if (strobe.shift) shiftTally <= shiftTally + SW'(1);
  end

  // R9: an add is always followed by a shift
  a_r9_add_then_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobe.add |=> strobe.shift);

  // R9: exactly OP_W shifts have happened by the time done is raised
  a_r9_shift_count: assert property (@(posedge clk) disable iff (!rstN)
    done |-> shiftTally == SW'(OP_W));

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: a request in the done cycle never causes a load
  a_r7_no_load_in_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !strobe.load);

  // R7: the datapath never sees two commands in one cycle
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.add, strobe.shift}));

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import shift_add_mul_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OP_W-1:0]   mcand,
  input  logic [OP_W-1:0]   mplier,
  output logic [2*OP_W:0]   product,
  output logic              done
);

  ctlStrobe_t strobe;
  logic       accLsb;

  sam_control #(.OP_W(OP_W)) u_control (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .accLsb (accLsb),
    .strobe (strobe),
    .done   (done)
  );

  sam_datapath #(.OP_W(OP_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mcandIn  (mcand),
    .mplierIn (mplier),
    .accOut   (product),
    .accLsb   (accLsb)
  );

endmodule

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] a = '0;
  logic [3:0] b = '0;
  logic [8:0] product;
  logic       done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  shift_add_mul u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .mcand(a), .mplier(b), .product(product), .done(done)
  );

  function automatic int ones(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Behavioural reference, stepped on each rising edge
  bit    mBusy = 0;
  bit    mDone = 0;
  bit    mKnown = 1;
  int    mProd = 0;
  int    mLeft = 0;
  int    mResult = 0;
  string mTag = "R1";

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mKnown = 1; mProd = 0; mTag = "R1";
    end else if (mBusy && mDone) begin
      mBusy = 0; mDone = 0; mTag = "R8";
    end else if (mBusy) begin
      mKnown = 0;
      mLeft--;
      if (mLeft == 0) begin
        mDone = 1; mKnown = 1; mProd = mResult; mTag = "R4";
      end
    end else if (start) begin
      mBusy = 1; mKnown = 1; mProd = int'(b); mTag = "R2";
      mResult = int'(a) * int'(b);
      mLeft = 4 + ones(b);
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    check(done == mDone, "R6 done", int'(done), int'(mDone));
    if (mKnown) check(int'(product) == mProd, mTag, int'(product), mProd);
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Start from an idle negedge; returns at the idle negedge after done
  task automatic runMul(input logic [3:0] x, input logic [3:0] y);
    int n = 0;
    start = 1'b1; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(n == 4 + ones(y), "R5 latency", n, 4 + ones(y));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(product == 9'd0 && done == 1'b0, "R1 in reset", int'(product), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(product == 9'd0 && done == 1'b0, "R1 after reset", int'(product), 0);

    // R4: all ones operands give 225
    runMul(4'hF, 4'hF);
    check(product == 9'b011100001, "R4 15x15", int'(product), 225);

    // R2: leftover upper bits must be cleared by the next load
    runMul(4'h1, 4'h0);
    check(product == 9'd0, "R2 clear after 225", int'(product), 0);

    // R4 R5: every operand pair
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        runMul(4'(i), 4'(j));
        check(int'(product) == i * j, "R4 sweep", int'(product), i * j);
      end
    end

    // R3: operand inputs change right after the accepting edge
    start = 1'b1; a = 4'd13; b = 4'd11;
    @(negedge clk);
    start = 1'b0; a = 4'd2; b = 4'd3;
    while (!done) @(negedge clk);
    check(product == 9'd143, "R3 captured operands", int'(product), 143);
    @(negedge clk);

    // R7: start pulse with new operands in the middle of a run
    start = 1'b1; a = 4'd9; b = 4'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; a = 4'd15; b = 4'd15;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(product == 9'd63, "R7 mid-run start", int'(product), 63);
    @(negedge clk);

    // R7: start held high through the done cycle, dropped there
    start = 1'b1; a = 4'd6; b = 4'd10;
    @(negedge clk);
    while (!done) @(negedge clk);
    start = 1'b0;
    check(product == 9'd60, "R7 held start", int'(product), 60);
    @(negedge clk);
    check(done == 1'b0, "R6 no repeat", int'(done), 0);

    // R8: product holds while idle
    repeat (4) @(negedge clk);
    check(product == 9'd60, "R8 hold idle", int'(product), 60);

    // R9: a multiplier of all ones needs eight step cycles, all zeros needs four
    runMul(4'd5, 4'd15);
    runMul(4'd5, 4'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule